// File: doc/BRIEF.md
# Parallel Flash Bus Front-End

This block sits behind the pins of a parallel NOR flash device and turns the three active-low enables (chip, output and write) into bus operations inside a fast synchronous clock domain. Each enable passes through a two-flop synchroniser and a low-pulse filter. A low level counts only after it has been seen for `GLITCH_CYC` consecutive samples. The filtered enables are decoded into standby, read, write and output-disable.

During a read, the block serves data combinationally from a stub cell array or from the identifier codes. For each lane of the data bus it drives a separate output-enable rather than an internal high-impedance value. The data bus can run word-wide or byte-wide. In byte-wide mode the top data pin acts as the lowest address bit.

During a write, the block captures the address when the second of chip-enable and write-enable becomes active. It captures the data when the first of the two is released. It then presents the address and data to a downstream command interpreter with a one-cycle strobe.

Top module: `flashbus_if`

## Requirements
- R1: In word mode (`byteN`=1), with chip and output enable active and write enable inactive, both `dqOeLo` and `dqOeHi` are 1. `dqOut` then shows the stub cell word at address `a`, which is `{a[7:0]^8'h5A, a[7:0]}`.
- R2: Both lane enables are 0 whenever chip enable is inactive (standby) or output enable is inactive (output disable).
- R3: A write address is taken at the moment the later of chip enable and write enable becomes active. Address changes before or after that moment do not affect `wrAddr`.
- R4: Write data is taken at the moment the earlier of chip enable and write enable is released. `wrStb` then pulses high for exactly one cycle, with `wrAddr` and `wrData` held valid.
- R5: A write during which output enable is active at any point produces no `wrStb`.
- R6: A low pulse on any enable that is shorter than `GLITCH_CYC` clock samples is ignored. Such a pulse causes neither a write strobe nor a driven data lane.
- R7: With `idHv`=1 during a read and `addr[1]`=0, `addr[0]`=0 returns the manufacturer code 0x0020 and `addr[0]`=1 returns the device code 0x00EF. Any other address returns 0.
- R8: In byte mode (`byteN`=0), `dqIn[15]` is the address bit below `addr[0]`. A read drives only the low lane (`dqOeHi`=0) with the low cell byte when that bit is 0 and the high cell byte when it is 1; identifier codes ignore the bit. A byte write reports `wrAddr`={addr, dqIn[15]} and `wrData`={8'h00, dqIn[7:0]}. A word write reports `wrAddr`={addr, 1'b0} and the full `dqIn`.
- R9: `busOp` encodes the decoded operation: 0 standby, 1 read, 2 write (chip and write enable active, output enable inactive), 3 output disable (every other case with chip enable active).
- R10: After reset `wrStb`, `wrAddr`, `wrData`, `dqOeLo` and `dqOeHi` are 0, and `busOp` reads 0 while chip enable is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| byteN | input | 1 | 1 = word-wide bus, 0 = byte-wide bus |
| idHv | input | 1 | Elevated-voltage flag on the identifier address line |
| addr | input | ADDR_W | Word address |
| dqIn | input | 16 | Data bus input (bit 15 is the extra address bit in byte mode) |
| dqOut | output | 16 | Data bus output value |
| dqOeLo | output | 1 | Drive enable for data bits 7..0 |
| dqOeHi | output | 1 | Drive enable for data bits 15..8 |
| busOp | output | 2 | Decoded bus operation |
| wrStb | output | 1 | One-cycle strobe for a captured write |
| wrAddr | output | ADDR_W+1 | Captured write byte address |
| wrData | output | 16 | Captured write data |

## Verification
An enable edge reaches the decoder two synchroniser cycles plus `GLITCH_CYC` filter cycles after it arrives. Once a read is decoded, the lane enables follow in the same cycle, and `dqOut` follows the address with no delay. A release is seen three cycles after the pin rises. The write strobe appears one cycle after the release is seen. The bench therefore holds each pin state for `GLITCH_CYC`+6 cycles before it samples, on the falling clock edge. It holds address and data for several cycles around each capture point, so that only the intended value can be captured. Strobes are counted on every falling edge over a whole scenario, so a missing, extra or stretched strobe shows up in the count.

// File: rtl/flashbus_pkg.sv
package flashbus_pkg;
  typedef struct packed {
    logic capAddr;
    logic capData;
    logic rdEn;
  } ctlStb_t;

  typedef enum logic [1:0] {
    OP_STANDBY = 2'd0,
    OP_READ    = 2'd1,
    OP_WRITE   = 2'd2,
    OP_OUTDIS  = 2'd3
  } busOp_e;

  localparam logic [7:0] MFR_CODE  = 8'h20;
  localparam logic [7:0] DEV_CODE  = 8'hEF;
  localparam logic [7:0] CELL_MASK = 8'h5A;
endpackage

// File: rtl/flashbus_glitch.sv
module flashbus_glitch #(
  parameter int GLITCH_CYC = 4,
  localparam int CNT_W = $clog2(GLITCH_CYC + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawN,
  output logic act
);
  logic syncA, syncB;
  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA  <= 1'b1;
      syncB  <= 1'b1;
      lowCnt <= '0;
    end else begin
      syncA <= rawN;
      syncB <= syncA;
      if (syncB) lowCnt <= '0;
      else if (lowCnt != CNT_W'(GLITCH_CYC)) lowCnt <= lowCnt + 1'b1;
    end
  end

  assign act = (lowCnt == CNT_W'(GLITCH_CYC));

  // R6: a released enable drops its active flag on the next cycle
  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    syncB |=> !act);
endmodule

// File: rtl/flashbus_ctrl.sv
module flashbus_ctrl
  import flashbus_pkg::*;
#(
  parameter int GLITCH_CYC = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    weN,
  output ctlStb_t ctl,
  output busOp_e  busOp
);
  localparam int N_EN = 3;
  logic [N_EN-1:0] rawN, act;
  logic ceAct, oeAct, weAct, inPhase, phasePrev, wrOk;

  assign rawN = {weN, oeN, ceN};

  generate
    for (genvar i = 0; i < N_EN; i++) begin : g_flt
      flashbus_glitch #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
        .clk (clk),
        .rstN(rstN),
        .rawN(rawN[i]),
        .act (act[i])
      );
    end
  endgenerate

  assign ceAct   = act[0];
  assign oeAct   = act[1];
  assign weAct   = act[2];
  assign inPhase = ceAct & weAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phasePrev <= 1'b0;
      wrOk      <= 1'b0;
    end else begin
      phasePrev <= inPhase;
      if (inPhase && !phasePrev) wrOk <= !oeAct;
      else if (inPhase && oeAct) wrOk <= 1'b0;
    end
  end

  always_comb begin
    ctl.capAddr = inPhase & ~phasePrev;
    ctl.capData = ~inPhase & phasePrev & wrOk & ~oeAct;
    ctl.rdEn    = ceAct & oeAct & ~weAct;
    if (!ceAct)               busOp = OP_STANDBY;
    else if (ctl.rdEn)        busOp = OP_READ;
    else if (weAct && !oeAct) busOp = OP_WRITE;
    else                      busOp = OP_OUTDIS;
  end

  // R5: output enable seen during a write phase cancels the data capture
  assert_oe_blocks_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inPhase && oeAct) |=> !ctl.capData);
  // R3: address capture is a single-cycle event per write phase
  assert_addr_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capAddr |=> !ctl.capAddr);
endmodule

// File: rtl/flashbus_dpath.sv
module flashbus_dpath
  import flashbus_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           ctl,
  input  logic              byteN,
  input  logic              idHv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dqIn,
  output logic [15:0]       dqOut,
  output logic              dqOeLo,
  output logic              dqOeHi,
  output logic              wrStb,
  output logic [ADDR_W:0]   wrAddr,
  output logic [15:0]       wrData
);
  logic [7:0]    cellLo, idByte;
  logic [15:0]   rdWord;
  logic          hiByteSel;
  logic [ADDR_W:0] addrHold;

  always_comb begin
    cellLo = 8'(addr);
    idByte = 8'h00;
    if (!addr[1]) idByte = addr[0] ? DEV_CODE : MFR_CODE;
    rdWord    = idHv ? {8'h00, idByte} : {cellLo ^ CELL_MASK, cellLo};
    hiByteSel = dqIn[15] & ~idHv;
    if (byteN) dqOut = rdWord;
    else       dqOut = {8'h00, hiByteSel ? rdWord[15:8] : rdWord[7:0]};
    dqOeLo = ctl.rdEn;
    dqOeHi = ctl.rdEn & byteN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHold <= '0;
      wrStb    <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStb <= ctl.capData;
      if (ctl.capAddr) addrHold <= {addr, byteN ? 1'b0 : dqIn[15]};
      if (ctl.capData) begin
        wrAddr <= addrHold;
        wrData <= byteN ? dqIn : {8'h00, dqIn[7:0]};
      end
    end
  end

  // R4: the write strobe never lasts more than one cycle
  assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);
  // R8: a byte-mode read drives the low lane only
  assert_byte_lane_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEn && !byteN) |-> (dqOeLo && !dqOeHi));
endmodule

// File: rtl/flashbus_if.sv
module flashbus_if
  import flashbus_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int GLITCH_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              byteN,
  input  logic              idHv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dqIn,
  output logic [15:0]       dqOut,
  output logic              dqOeLo,
  output logic              dqOeHi,
  output logic [1:0]        busOp,
  output logic              wrStb,
  output logic [ADDR_W:0]   wrAddr,
  output logic [15:0]       wrData
);
  ctlStb_t ctl;
  busOp_e  opDec;

  flashbus_ctrl #(.GLITCH_CYC(GLITCH_CYC)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ceN  (ceN),
    .oeN  (oeN),
    .weN  (weN),
    .ctl  (ctl),
    .busOp(opDec)
  );

  flashbus_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .byteN (byteN),
    .idHv  (idHv),
    .addr  (addr),
    .dqIn  (dqIn),
    .dqOut (dqOut),
    .dqOeLo(dqOeLo),
    .dqOeHi(dqOeHi),
    .wrStb (wrStb),
    .wrAddr(wrAddr),
    .wrData(wrData)
  );

  assign busOp = opDec;
endmodule

// File: tb/flashbus_if_bench.sv
module flashbus_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int GLITCH_CYC = 4;
  localparam int SETTLE     = GLITCH_CYC + 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, byteN = 1'b1, idHv = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] dqOut;
  logic dqOeLo, dqOeHi, wrStb;
  logic [1:0] busOp;
  logic [ADDR_W:0] wrAddr;
  logic [15:0] wrData;

  int nChk = 0, nFail = 0, stbCnt = 0, driveSeen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flashbus_if #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC)) u_flashbus_if (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .byteN(byteN),
    .idHv(idHv), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOeLo(dqOeLo),
    .dqOeHi(dqOeHi), .busOp(busOp), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData)
  );

  always @(negedge clk) begin
    if (rstN && wrStb) stbCnt++;
    if (rstN && (dqOeLo || dqOeHi)) driveSeen++;
  end

  function automatic logic [15:0] cellWord(logic [7:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idleBus();
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1; idHv = 1'b0; byteN = 1'b1;
    cyc(SETTLE);
  endtask

  task automatic tReset();
    chk("R10 wrStb", wrStb, 0);
    chk("R10 wrAddr", wrAddr, 0);
    chk("R10 wrData", wrData, 0);
    chk("R10 lanes", {dqOeHi, dqOeLo}, 0);
    chk("R10 busOp", busOp, 0);
  endtask

  task automatic tWordRead();
    byteN = 1'b1; addr = 8'h3C; ceN = 1'b0; oeN = 1'b0;
    cyc(SETTLE);
    chk("R1 lanes", {dqOeHi, dqOeLo}, 2'b11);
    chk("R1 data 3C", dqOut, cellWord(8'h3C));
    chk("R9 busOp read", busOp, 1);
    addr = 8'hC1; #1;
    chk("R1 data C1", dqOut, cellWord(8'hC1));
    oeN = 1'b1; cyc(SETTLE);
    chk("R2 outdis lanes", {dqOeHi, dqOeLo}, 0);
    chk("R9 busOp outdis", busOp, 3);
    ceN = 1'b1; oeN = 1'b0; cyc(SETTLE);
    chk("R2 standby lanes", {dqOeHi, dqOeLo}, 0);
    chk("R9 busOp standby", busOp, 0);
    idleBus();
  endtask

  task automatic tIdRead();
    idHv = 1'b1; ceN = 1'b0; oeN = 1'b0; addr = 8'h00;
    cyc(SETTLE);
    chk("R7 manufacturer", dqOut, 16'h0020);
    addr = 8'h01; #1;
    chk("R7 device", dqOut, 16'h00EF);
    addr = 8'h02; #1;
    chk("R7 other", dqOut, 16'h0000);
    byteN = 1'b0; addr = 8'h01; dqIn[15] = 1'b1; cyc(SETTLE);
    chk("R8 byte id", dqOut, 16'h00EF);
    chk("R8 byte id lanes", {dqOeHi, dqOeLo}, 2'b01);
    dqIn = '0;
    idleBus();
  endtask

  task automatic tByteRead();
    byteN = 1'b0; addr = 8'h47; dqIn[15] = 1'b0; ceN = 1'b0; oeN = 1'b0;
    cyc(SETTLE);
    chk("R8 low byte", dqOut, {8'h00, cellWord(8'h47)[7:0]});
    chk("R8 lanes", {dqOeHi, dqOeLo}, 2'b01);
    dqIn[15] = 1'b1; #1;
    chk("R8 high byte", dqOut, {8'h00, cellWord(8'h47)[15:8]});
    dqIn = '0;
    idleBus();
  endtask

  // ceFirst: ce falls first, we rises first; otherwise the opposite.
  // Address a2 is present only around the later fall, data d1 only around the earlier rise.
  task automatic tWriteOrder(bit ceFirst, logic [7:0] a2, logic [15:0] d1);
    int s0 = stbCnt;
    byteN = 1'b1; oeN = 1'b1; addr = 8'h11; dqIn = 16'h0BAD;
    if (ceFirst) ceN = 1'b0; else weN = 1'b0;
    cyc(SETTLE);
    addr = a2;
    if (ceFirst) weN = 1'b0; else ceN = 1'b0;
    cyc(SETTLE);
    addr = 8'h22; dqIn = d1;
    cyc(2);
    if (ceFirst) weN = 1'b1; else ceN = 1'b1;
    cyc(SETTLE);
    dqIn = 16'hDEAD;
    cyc(2);
    if (ceFirst) ceN = 1'b1; else weN = 1'b1;
    cyc(SETTLE);
    chk("R4 one strobe", stbCnt - s0, 1);
    chk("R3 later-fall address", wrAddr, {1'b0, a2, 1'b0});
    chk("R4 earlier-rise data", wrData, d1);
    idleBus();
  endtask

  task automatic tByteWrite();
    int s0 = stbCnt;
    byteN = 1'b0; oeN = 1'b1; addr = 8'h5E; dqIn = 16'h80C4;
    ceN = 1'b0; weN = 1'b0; cyc(SETTLE);
    weN = 1'b1; cyc(SETTLE);
    ceN = 1'b1; cyc(SETTLE);
    chk("R8 byte write strobe", stbCnt - s0, 1);
    chk("R8 byte write addr", wrAddr, {1'b0, 8'h5E, 1'b1});
    chk("R8 byte write data", wrData, 16'h00C4);
    dqIn = '0;
    idleBus();
  endtask

  task automatic tOeWrite();
    int s0 = stbCnt;
    oeN = 1'b1; addr = 8'h77; dqIn = 16'h1234;
    ceN = 1'b0; weN = 1'b0; cyc(SETTLE);
    oeN = 1'b0; cyc(SETTLE);
    oeN = 1'b1; cyc(SETTLE);
    weN = 1'b1; cyc(SETTLE);
    ceN = 1'b1; cyc(SETTLE);
    chk("R5 no strobe oe mid-write", stbCnt - s0, 0);
    chk("R5 data unchanged", wrData, 16'h00C4);
    idleBus();
  endtask

  task automatic tGlitch();
    int s0 = stbCnt;
    int d0;
    oeN = 1'b1; addr = 8'h99; dqIn = 16'h5555; ceN = 1'b0; cyc(SETTLE);
    weN = 1'b0; cyc(GLITCH_CYC - 1); weN = 1'b1; cyc(SETTLE);
    chk("R6 short we pulse", stbCnt - s0, 0);
    d0 = driveSeen;
    oeN = 1'b0; cyc(GLITCH_CYC - 1); oeN = 1'b1; cyc(SETTLE);
    chk("R6 short oe pulse no drive", driveSeen - d0, 0);
    weN = 1'b0; cyc(GLITCH_CYC); weN = 1'b1; cyc(SETTLE);
    chk("R6 minimum pulse accepted", stbCnt - s0, 1);
    chk("R6 minimum pulse data", wrData, 16'h5555);
    idleBus();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(2);
    tReset();
    tWordRead();
    tIdRead();
    tByteRead();
    tWriteOrder(1'b1, 8'hA3, 16'hC0DE);
    tWriteOrder(1'b0, 8'h4B, 16'h7E11);
    tByteWrite();
    tOeWrite();
    tGlitch();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule